// File: doc/BRIEF.md
# Serial Trim Code Shift Register

This block takes an 11-bit trim control word from a two-wire serial link, one serial clock pin and one data pin, and turns it into a 10-bit capacitor code for an analog trim array. Both pins are oversampled by a fast system clock. Each rising edge of the serial clock moves one data bit into the shift register. The level of the serial clock also picks the code source. While the serial clock is high, the shifted word drives the code. While it is low, a stored non-volatile word drives it. That stored word comes in on an input port.

The lowest register bit is a check bit and takes no part in the code. The code itself is split into two coarse fields and one fine field for the capacitor array. The host sends the check bit first. The block does not count edges. A host that gives an extra clock pulse corrupts the word, and the block does exactly that on purpose. An undriven link reads as all zeros, so after reset the block is in stored-word mode.

Top module: `trim_serial_link`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the code outputs to zero. After reset, the first rising serial edge with data 1 gives code 10'h200.
- R2: Each rising edge of the serial clock puts the sampled data bit into register bit 10 and moves every other bit one place toward bit 0. After 11 edges, the bit sent first sits in bit 0.
- R3: While the synchronized serial clock is high, cap_code_o equals register bits 10:1.
- R4: While the synchronized serial clock is low, cap_code_o equals stored_word_i bits 10:1, and it follows changes of stored_word_i.
- R5: Register bit 0 (the check bit, sent first) never affects cap_code_o.
- R6: A 12th rising edge after a complete word shifts in one more bit. The code becomes {new bit, old word bits 10:2}.
- R7: coarse_hi_o carries code bits 9:8 (register 10:9), coarse_lo_o carries code bits 7:5 (register 8:6), and fine_o carries code bits 4:0 (register 5:1).
- R8: After a level change on the serial clock pin, the outputs take the new source's value at the third rising system clock edge, and not before.
- R9: Data changes while the serial clock stays high, and falling serial edges, leave the register and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock pin; its level also selects the code source |
| ser_dat_i | input | 1 | Serial data pin |
| stored_word_i | input | 11 | Stored non-volatile trim word (bit 0 is the check bit) |
| cap_code_o | output | 10 | Capacitor code |
| coarse_hi_o | output | 2 | First coarse tuning field |
| coarse_lo_o | output | 3 | Second coarse tuning field |
| fine_o | output | 5 | Fine tuning field |

## Verification
The bench loads two words that differ only in the check bit. A design that counted the check bit would give two different codes. An extra pulse after a complete word must shift the word, so a design that guarded against excess edges, or shifted the wrong way, would leave the code untouched or reversed. Data is toggled while the serial clock is held high, and the fields are checked against a known word. These tests catch a design that shifts on level instead of on edge, or that slices the fields off by one. Source switching is sampled one cycle before and at the expected update edge, both into and out of shift mode. A missing or extra synchronizer stage shows up there as a one-cycle shift.

// File: rtl/trim_serial_pkg.sv
package trim_serial_pkg;
  localparam int WORD_W   = 11;
  localparam int CODE_W   = WORD_W - 1;
  localparam int CHI_W    = 2;
  localparam int CLO_W    = 3;
  localparam int FINE_W   = CODE_W - CHI_W - CLO_W;
  localparam int FINE_LSB = 1;
  localparam int CLO_LSB  = FINE_LSB + FINE_W;
  localparam int CHI_LSB  = CLO_LSB + CLO_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/trim_pin_sync.sv
module trim_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/trim_word_shifter.sv
module trim_word_shifter
  import trim_serial_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  shift_en,
  input  logic  din,
  output word_t sreg_q,
  output word_t sreg_nxt
);
  always_comb begin
    sreg_nxt = sreg_q;
    if (shift_en) sreg_nxt = {din, sreg_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) sreg_q <= '0;
    else     sreg_q <= sreg_nxt;
  end
endmodule

// File: rtl/trim_code_select.sv
module trim_code_select
  import trim_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              use_reg,
  input  word_t             reg_word,
  input  word_t             nv_word,
  output code_t             code_o,
  output logic [CHI_W-1:0]  chi_o,
  output logic [CLO_W-1:0]  clo_o,
  output logic [FINE_W-1:0] fine_o
);
  word_t pick;

  always_comb pick = use_reg ? reg_word : nv_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      chi_o  <= '0;
      clo_o  <= '0;
      fine_o <= '0;
    end else begin
      code_o <= pick[WORD_W-1:1];
      chi_o  <= pick[CHI_LSB +: CHI_W];
      clo_o  <= pick[CLO_LSB +: CLO_W];
      fine_o <= pick[FINE_LSB +: FINE_W];
    end
  end
endmodule

// File: rtl/trim_serial_link.sv
module trim_serial_link
  import trim_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic [10:0]       stored_word_i,
  output logic [9:0]        cap_code_o,
  output logic [1:0]        coarse_hi_o,
  output logic [2:0]        coarse_lo_o,
  output logic [4:0]        fine_o
);
  localparam int PIN_CLK = 0;
  localparam int PIN_DAT = 1;

  logic [1:0] pin_lvl, pin_rise;
  word_t      sreg_q, sreg_nxt;

  trim_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({ser_dat_i, ser_clk_i}),
    .lvl_o(pin_lvl), .rise_o(pin_rise)
  );

  trim_word_shifter u_shift (
    .clk(clk), .rst(rst),
    .shift_en(pin_rise[PIN_CLK]), .din(pin_lvl[PIN_DAT]),
    .sreg_q(sreg_q), .sreg_nxt(sreg_nxt)
  );

  trim_code_select u_sel (
    .clk(clk), .rst(rst),
    .use_reg(pin_lvl[PIN_CLK]), .reg_word(sreg_nxt), .nv_word(stored_word_i),
    .code_o(cap_code_o), .chi_o(coarse_hi_o), .clo_o(coarse_lo_o), .fine_o(fine_o)
  );
endmodule

// File: rtl/trim_serial_link_chk.sv
module trim_serial_link_chk (
  input logic        clk,
  input logic        rst,
  input logic        lvl_clk,
  input logic        rise_clk,
  input logic [10:0] sreg,
  input logic [10:0] nv_word,
  input logic [9:0]  code
);
  assert_shift_src_R3: assert property (@(posedge clk) disable iff (rst)
    lvl_clk |=> code == sreg[10:1]);

  assert_nv_src_R4: assert property (@(posedge clk) disable iff (rst)
    !lvl_clk |=> code == $past(nv_word[10:1]));

  assert_shift_dir_R2: assert property (@(posedge clk) disable iff (rst)
    rise_clk |=> sreg[9:0] == $past(sreg[10:1]));

  assert_no_shift_R9: assert property (@(posedge clk) disable iff (rst)
    !rise_clk |=> $stable(sreg));
endmodule

bind trim_serial_link trim_serial_link_chk u_chk (
  .clk(clk), .rst(rst), .lvl_clk(pin_lvl[0]), .rise_clk(pin_rise[0]),
  .sreg(sreg_q), .nv_word(stored_word_i), .code(cap_code_o)
);

// File: tb/test_trim_serial_link.sv
module test_trim_serial_link;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic [10:0] nv = 11'b10110011010;
  logic [9:0]  code;
  logic [1:0]  chi;
  logic [2:0]  clo;
  logic [4:0]  fine;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  trim_serial_link i_trim_serial_link (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .stored_word_i(nv), .cap_code_o(code), .coarse_hi_o(chi),
    .coarse_lo_o(clo), .fine_o(fine)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_clk = 1'b0; ser_dat = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_word(input logic [10:0] w);
    for (int i = 0; i < 11; i++) send_bit(w[i]);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", code, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 stored word after reset", code, nv[10:1]);
    send_bit(1'b1);
    chk("R1 zeroed register plus one bit", code, 10'h200);
  endtask

  task automatic t_load;
    logic [10:0] w = 11'b01011101111;
    load_word(w);
    chk("R3 shifted word drives code", code, w[10:1]);
    chk("R7 coarse_hi", chi, 2'b01);
    chk("R7 coarse_lo", clo, 3'b011);
    chk("R7 fine", fine, 5'b10111);
  endtask

  task automatic t_mode;
    @(negedge clk); ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 low clock selects stored word", code, nv[10:1]);
    nv = 11'b01100101101;
    repeat (2) @(negedge clk);
    chk("R4 follows stored word change", code, nv[10:1]);
  endtask

  task automatic t_check_bit;
    logic [9:0] c0;
    load_word(11'b10011100110);
    c0 = code;
    load_word(11'b10011100111);
    chk("R5 check bit ignored", code, c0);
  endtask

  task automatic t_extra;
    logic [10:0] w = 11'b11000110101;
    load_word(w);
    send_bit(1'b0);
    chk("R6 extra edge shifts word", code, {1'b0, w[10:2]});
  endtask

  task automatic t_hold;
    logic [10:0] w = 11'b00111010011;
    load_word(w);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ser_dat = ~ser_dat;
      repeat (4) @(negedge clk);
    end
    chk("R9 data toggles with clock high", code, w[10:1]);
  endtask

  task automatic t_latency;
    logic [10:0] w = 11'b10101010110;
    load_word(w);
    @(negedge clk); ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 falling not yet seen", code, w[10:1]);
    @(negedge clk);
    chk("R8 falling seen at third edge", code, nv[10:1]);
    repeat (2) @(negedge clk);
    ser_clk = 1'b1; ser_dat = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 rising not yet seen", code, nv[10:1]);
    @(negedge clk);
    chk("R8 rising seen at third edge", code, {1'b1, w[10:2]});
  endtask

  initial begin
    #(200000 * 8ns);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_mode();
    t_check_bit();
    t_extra();
    t_hold();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule